// File: doc/BRIEF.md
# FM Synthesizer Register Write Decoder

This block sits behind the host write port of a two-bank FM sound generator. The host first writes a register address, together with a bank select, and then one or more data bytes. For each data byte the block works out what the addressed register controls. It then issues a one-cycle strobe with the decoded fields for one of four targets: an operator slot, a channel, the percussion register, or the internal pairing and mode state.

Operator addresses are sparse, with holes in each bank. The block folds them onto a dense slot index running from 0 to 35. Channel writes are tagged with a channel index from 0 to 17.

A channel can be paired with a partner channel to form a four-operator voice. When that happens, the partner ("upper") channel stops taking frequency and key writes. Key state is kept for each channel. A key event carries a mask of the operator slots it drives, and it is raised only when the stored key bit actually changes.

Top module: `fm_reg_decoder`

## Requirements
- R1: After reset, `op_we_o`, `ch_we_o`, `key_ev_o`, `perc_we_o`, `pair_o` and `ext_mode_o` are all zero, every stored key bit is off, and the latched address is 0.
- R2: A cycle with `addr_we_i` high latches `wdata_i` as the address and `bank_i` as the bank. A cycle with `data_we_i` high uses the address latched before that cycle. Each result appears on the outputs exactly one cycle later. When the latched address is 0, a data write has no effect on any output.
- R3: Addresses whose bits 7:5 equal 1, 2, 3, 4 or 7 are operator writes, and `op_grp_o` carries those three bits. The offset `o` is taken from address bits 4:0. Offsets 6, 7, 14, 15 and anything above 21 are ignored. Otherwise `op_slot_o` = 18·bank + `o` − 2·(`o`≥8) − 2·(`o`≥16).
- R4: On each operator strobe, the fields are decoded from the data byte as follows: `op_mult_o` = d[3:0], `op_sus_en_o` = d[5], `op_am_o` = d[7], and `op_tl_o` = d[5:0].
- R5: Rates are 5 bits wide, formed as the nibble followed by a 1: `op_ar_o` = {d[7:4],1}, `op_dr_o` = {d[3:0],1}, and `op_rr_o` = {d[3:0],1}.
- R6: `op_sl_o` is d[7:4] zero-extended to 5 bits. The one exception is a nibble of 15, which gives 31 (full attenuation).
- R7: `op_wave_o` is d[2:0] when extended mode is on and {0,d[1:0]} when it is off. The mode used is the value held before the write.
- R8: Addresses 0xA0–0xCF are channel writes. Their low nibble `c` must be 8 or less; larger values are ignored. `ch_idx_o` = 9·bank + `c`. `ch_grp_o` is 0 for the 0xAx group, 1 for 0xBx and 2 for 0xCx. The fields are `ch_fnum_lo_o` = d, `ch_fnum_hi_o` = d[1:0], `ch_block_o` = d[4:2], `ch_key_o` = d[5], `ch_conn_o` = d[0], `ch_fb_o` = d[3:1] and `ch_out_en_o` = d[7:4]. Addresses 0xD0–0xDF are ignored.
- R9: Writes to the 0xAx or 0xBx group with `c` in 3..5 are dropped when extended mode is on and pairing bit 3·bank + `c` − 3 is set. Writes to the 0xCx group are never dropped for this reason.
- R10: An accepted 0xBx write raises `key_ev_o` only when d[5] differs from the stored key bit of that channel. In that case `key_on_o` = d[5]. The write always updates the stored bit.
- R11: The base slot of a key event is b = 18·bank + `c` + 3·(`c`≥3) + 3·(`c`≥6). `key_mask_o` sets bits b and b+3. When extended mode is on, `c` < 3, and pairing bit 3·bank + `c` is set, it also sets bits b+6 and b+9.
- R12: In bank 0, address 0x04 loads `pair_o` with d[5:0] and address 0x05 loads `ext_mode_o` with d[0]. Every other address below 0x20 is ignored in both banks.
- R13: Address 0xBD in bank 0 raises `perc_we_o` with `perc_o` = d. The same address in bank 1 is ignored.
- R14: At most one of `op_we_o`, `ch_we_o` and `perc_we_o` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_we_i | input | 1 | Latch `wdata_i` as register address |
| bank_i | input | 1 | Bank select, latched with the address |
| data_we_i | input | 1 | Data write to the latched address |
| wdata_i | input | 8 | Address or data byte |
| op_we_o | output | 1 | Operator field strobe |
| op_grp_o | output | 3 | Operator register group (address bits 7:5) |
| op_slot_o | output | 6 | Folded operator slot |
| op_mult_o | output | 4 | Frequency multiplier |
| op_sus_en_o | output | 1 | Sustain enable |
| op_am_o | output | 1 | Amplitude modulation enable |
| op_tl_o | output | 6 | Total level |
| op_ar_o | output | 5 | Attack rate |
| op_dr_o | output | 5 | Decay rate |
| op_rr_o | output | 5 | Release rate |
| op_sl_o | output | 5 | Sustain level |
| op_wave_o | output | 3 | Waveform select |
| ch_we_o | output | 1 | Channel field strobe |
| ch_grp_o | output | 2 | Channel group: 0 frequency low, 1 key/block, 2 connection |
| ch_idx_o | output | 5 | Channel index |
| ch_fnum_lo_o | output | 8 | Frequency number bits 7:0 |
| ch_fnum_hi_o | output | 2 | Frequency number bits 9:8 |
| ch_block_o | output | 3 | Octave block |
| ch_key_o | output | 1 | Key bit as written |
| ch_conn_o | output | 1 | Connection bit |
| ch_fb_o | output | 3 | Feedback |
| ch_out_en_o | output | 4 | Output enables |
| key_ev_o | output | 1 | Key event strobe |
| key_on_o | output | 1 | 1 key-on, 0 key-off |
| key_mask_o | output | 36 | Operator slots of the key event |
| perc_we_o | output | 1 | Percussion register strobe |
| perc_o | output | 8 | Percussion register value |
| pair_o | output | 6 | Pairing register |
| ext_mode_o | output | 1 | Extended mode enable |

## Verification
Two pieces of hidden state can go wrong: a corrupted key bit or a stale mode or pairing value. Neither shows up until the next write that depends on it. A wrong key bit shows up on the next 0xBx write to that channel, as a missing or spurious `key_ev_o`. A wrong pairing or mode value shows up as a dropped or accepted upper-channel write, a two-slot or four-slot mask, or a narrowed waveform select, and only one cycle after the write that consults it. For this reason the random stream mixes mode and pairing writes among the channel writes, and it revisits the same channels so that each channel's stored key bit is compared against its following write.

// File: rtl/fm_dec_pkg.sv
package fm_dec_pkg;
  localparam int CH_PER_BANK    = 9;
  localparam int OPS_PER_BANK   = 18;
  localparam int PAIRS_PER_BANK = 3;

  typedef enum logic [2:0] {
    OG_MULT   = 3'd1,
    OG_LEVEL  = 3'd2,
    OG_ATKDEC = 3'd3,
    OG_SUSREL = 3'd4,
    OG_WAVE   = 3'd7
  } op_grp_e;

  typedef enum logic [1:0] {
    CG_FLO  = 2'd0,
    CG_KEY  = 2'd1,
    CG_CONN = 2'd2
  } ch_grp_e;

  typedef struct packed {
    logic [3:0] mult;
    logic       sus_en;
    logic       am;
    logic [5:0] tl;
    logic [4:0] ar;
    logic [4:0] dr;
    logic [4:0] rr;
    logic [4:0] sl;
    logic [2:0] wave;
  } op_fields_t;

  typedef struct packed {
    logic [7:0] fnum_lo;
    logic [1:0] fnum_hi;
    logic [2:0] block;
    logic       key;
    logic       conn;
    logic [2:0] fb;
    logic [3:0] out_en;
  } ch_fields_t;
endpackage

// File: rtl/fm_op_decode.sv
module fm_op_decode import fm_dec_pkg::*; #(
  parameter int NUM_BANKS = 2,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int NUM_SLOTS = NUM_BANKS * OPS_PER_BANK,
  localparam int SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic [7:0]        addr_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              ext_i,
  input  logic [7:0]        data_i,
  output logic              hit_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic [2:0]        grp_o,
  output op_fields_t        fields_o
);
  logic [4:0] off;
  logic [4:0] folded;
  logic       grp_ok;
  logic       hole;

  always_comb begin
    off    = addr_i[4:0];
    grp_o  = addr_i[7:5];
    grp_ok = (grp_o == OG_MULT) || (grp_o == OG_LEVEL) || (grp_o == OG_ATKDEC) ||
             (grp_o == OG_SUSREL) || (grp_o == OG_WAVE);
    // holes at 6..7, 14..15 and beyond 21
    hole   = (off[4:1] == 4'd3) || (off[4:1] == 4'd7) || (off > 5'd21);
    hit_o  = grp_ok && !hole;
    if (off >= 5'd16)     folded = off - 5'd4;
    else if (off >= 5'd8) folded = off - 5'd2;
    else                  folded = off;
    slot_o = SLOT_W'(int'(bank_i) * OPS_PER_BANK + int'(folded));
  end

  always_comb begin
    fields_o.mult   = data_i[3:0];
    fields_o.sus_en = data_i[5];
    fields_o.am     = data_i[7];
    fields_o.tl     = data_i[5:0];
    fields_o.ar     = {data_i[7:4], 1'b1};
    fields_o.dr     = {data_i[3:0], 1'b1};
    fields_o.rr     = {data_i[3:0], 1'b1};
    fields_o.sl     = (data_i[7:4] == 4'hF) ? 5'h1F : {1'b0, data_i[7:4]};
    fields_o.wave   = ext_i ? data_i[2:0] : {1'b0, data_i[1:0]};
  end
endmodule

// File: rtl/fm_ch_decode.sv
module fm_ch_decode import fm_dec_pkg::*; #(
  parameter int NUM_BANKS = 2,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int NUM_CH    = NUM_BANKS * CH_PER_BANK,
  localparam int NUM_SLOTS = NUM_BANKS * OPS_PER_BANK,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int PAIR_W    = NUM_BANKS * PAIRS_PER_BANK
) (
  input  logic [7:0]           addr_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 ext_i,
  input  logic [PAIR_W-1:0]    pair_i,
  input  logic [7:0]           data_i,
  output logic                 hit_o,
  output logic                 key_wr_o,
  output logic [CH_W-1:0]      idx_o,
  output logic [1:0]           grp_o,
  output ch_fields_t           fields_o,
  output logic [NUM_SLOTS-1:0] mask_o
);
  logic [3:0] hi;
  logic [3:0] coff;
  logic       grp_ok;
  logic       paired;
  logic       upper_drop;
  logic       four_op;
  int         pb;
  int         base;

  always_comb begin
    hi     = addr_i[7:4];
    coff   = addr_i[3:0];
    grp_ok = (hi == 4'hA) || (hi == 4'hB) || (hi == 4'hC);
    grp_o  = hi[1:0] ^ 2'b10;
    pb     = int'(bank_i) * PAIRS_PER_BANK + ((coff > 4'd2) ? int'(coff) - 3 : int'(coff));
    paired = ext_i && (coff < 4'd6) && pair_i[pb];
    upper_drop = (hi != 4'hC) && (coff >= 4'd3) && paired;
    hit_o    = grp_ok && (coff <= 4'd8) && !upper_drop;
    key_wr_o = hit_o && (hi == 4'hB);
    four_op  = paired && (coff < 4'd3);
    idx_o    = CH_W'(int'(bank_i) * CH_PER_BANK + int'(coff));
    base     = int'(bank_i) * OPS_PER_BANK + int'(coff) +
               ((coff > 4'd5) ? 6 : (coff > 4'd2) ? 3 : 0);
  end

  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      mask_o[s] = (s == base) || (s == base + 3) ||
                  (four_op && ((s == base + 6) || (s == base + 9)));
    end
  end

  always_comb begin
    fields_o.fnum_lo = data_i;
    fields_o.fnum_hi = data_i[1:0];
    fields_o.block   = data_i[4:2];
    fields_o.key     = data_i[5];
    fields_o.conn    = data_i[0];
    fields_o.fb      = data_i[3:1];
    fields_o.out_en  = data_i[7:4];
  end
endmodule

// File: rtl/fm_key_track.sv
module fm_key_track import fm_dec_pkg::*; #(
  parameter int NUM_BANKS = 2,
  localparam int NUM_CH    = NUM_BANKS * CH_PER_BANK,
  localparam int NUM_SLOTS = NUM_BANKS * OPS_PER_BANK,
  localparam int CH_W      = $clog2(NUM_CH)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 key_wr_i,
  input  logic [CH_W-1:0]      idx_i,
  input  logic                 key_i,
  input  logic [NUM_SLOTS-1:0] mask_i,
  output logic                 key_ev_o,
  output logic                 key_on_o,
  output logic [NUM_SLOTS-1:0] key_mask_o
);
  logic [NUM_CH-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      key_q      <= '0;
      key_ev_o   <= 1'b0;
      key_on_o   <= 1'b0;
      key_mask_o <= '0;
    end else begin
      key_ev_o <= key_wr_i && (key_q[idx_i] != key_i);
      if (key_wr_i) begin
        key_q[idx_i] <= key_i;
        key_on_o     <= key_i;
        key_mask_o   <= mask_i;
      end
    end
  end

  AST_KEY_MASK_SIZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ev_o |-> ($countones(key_mask_o) == 2 || $countones(key_mask_o) == 4)); // R11
  AST_KEY_REPEAT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (key_ev_o && key_wr_i && idx_i == $past(idx_i) && key_i == key_on_o) |=> !key_ev_o); // R10
endmodule

// File: rtl/fm_reg_decoder.sv
module fm_reg_decoder import fm_dec_pkg::*; #(
  parameter int NUM_BANKS = 2,
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int NUM_CH    = NUM_BANKS * CH_PER_BANK,
  localparam int NUM_SLOTS = NUM_BANKS * OPS_PER_BANK,
  localparam int CH_W      = $clog2(NUM_CH),
  localparam int SLOT_W    = $clog2(NUM_SLOTS),
  localparam int PAIR_W    = NUM_BANKS * PAIRS_PER_BANK
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 addr_we_i,
  input  logic [BANK_W-1:0]    bank_i,
  input  logic                 data_we_i,
  input  logic [7:0]           wdata_i,
  output logic                 op_we_o,
  output logic [2:0]           op_grp_o,
  output logic [SLOT_W-1:0]    op_slot_o,
  output logic [3:0]           op_mult_o,
  output logic                 op_sus_en_o,
  output logic                 op_am_o,
  output logic [5:0]           op_tl_o,
  output logic [4:0]           op_ar_o,
  output logic [4:0]           op_dr_o,
  output logic [4:0]           op_rr_o,
  output logic [4:0]           op_sl_o,
  output logic [2:0]           op_wave_o,
  output logic                 ch_we_o,
  output logic [1:0]           ch_grp_o,
  output logic [CH_W-1:0]      ch_idx_o,
  output logic [7:0]           ch_fnum_lo_o,
  output logic [1:0]           ch_fnum_hi_o,
  output logic [2:0]           ch_block_o,
  output logic                 ch_key_o,
  output logic                 ch_conn_o,
  output logic [2:0]           ch_fb_o,
  output logic [3:0]           ch_out_en_o,
  output logic                 key_ev_o,
  output logic                 key_on_o,
  output logic [NUM_SLOTS-1:0] key_mask_o,
  output logic                 perc_we_o,
  output logic [7:0]           perc_o,
  output logic [PAIR_W-1:0]    pair_o,
  output logic                 ext_mode_o
);
  logic [7:0]        addr_q;
  logic [BANK_W-1:0] bank_q;
  logic              live_wr;

  logic              op_hit;
  logic [SLOT_W-1:0] op_slot;
  logic [2:0]        op_grp;
  op_fields_t        op_f, op_f_q;

  logic                 ch_hit, key_wr;
  logic [CH_W-1:0]      ch_idx;
  logic [1:0]           ch_grp;
  ch_fields_t           ch_f, ch_f_q;
  logic [NUM_SLOTS-1:0] ch_mask;

  logic bank0, pair_wr, mode_wr, perc_wr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      bank_q <= '0;
    end else if (addr_we_i) begin
      addr_q <= wdata_i;
      bank_q <= bank_i;
    end
  end

  assign live_wr = data_we_i && (addr_q != 8'h00);
  assign bank0   = (bank_q == '0);
  assign pair_wr = live_wr && bank0 && (addr_q == 8'h04);
  assign mode_wr = live_wr && bank0 && (addr_q == 8'h05);
  assign perc_wr = live_wr && bank0 && (addr_q == 8'hBD);

  fm_op_decode #(.NUM_BANKS(NUM_BANKS)) u_op_dec (
    .addr_i   (addr_q),
    .bank_i   (bank_q),
    .ext_i    (ext_mode_o),
    .data_i   (wdata_i),
    .hit_o    (op_hit),
    .slot_o   (op_slot),
    .grp_o    (op_grp),
    .fields_o (op_f)
  );

  fm_ch_decode #(.NUM_BANKS(NUM_BANKS)) u_ch_dec (
    .addr_i   (addr_q),
    .bank_i   (bank_q),
    .ext_i    (ext_mode_o),
    .pair_i   (pair_o),
    .data_i   (wdata_i),
    .hit_o    (ch_hit),
    .key_wr_o (key_wr),
    .idx_o    (ch_idx),
    .grp_o    (ch_grp),
    .fields_o (ch_f),
    .mask_o   (ch_mask)
  );

  fm_key_track #(.NUM_BANKS(NUM_BANKS)) u_key (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .key_wr_i   (live_wr && key_wr),
    .idx_i      (ch_idx),
    .key_i      (ch_f.key),
    .mask_i     (ch_mask),
    .key_ev_o   (key_ev_o),
    .key_on_o   (key_on_o),
    .key_mask_o (key_mask_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_we_o    <= 1'b0;
      op_grp_o   <= '0;
      op_slot_o  <= '0;
      op_f_q     <= '0;
      ch_we_o    <= 1'b0;
      ch_grp_o   <= '0;
      ch_idx_o   <= '0;
      ch_f_q     <= '0;
      perc_we_o  <= 1'b0;
      perc_o     <= '0;
      pair_o     <= '0;
      ext_mode_o <= 1'b0;
    end else begin
      op_we_o   <= live_wr && op_hit;
      ch_we_o   <= live_wr && ch_hit;
      perc_we_o <= perc_wr;
      if (live_wr && op_hit) begin
        op_grp_o  <= op_grp;
        op_slot_o <= op_slot;
        op_f_q    <= op_f;
      end
      if (live_wr && ch_hit) begin
        ch_grp_o <= ch_grp;
        ch_idx_o <= ch_idx;
        ch_f_q   <= ch_f;
      end
      if (perc_wr) perc_o     <= wdata_i;
      if (pair_wr) pair_o     <= wdata_i[PAIR_W-1:0];
      if (mode_wr) ext_mode_o <= wdata_i[0];
    end
  end

  assign op_mult_o    = op_f_q.mult;
  assign op_sus_en_o  = op_f_q.sus_en;
  assign op_am_o      = op_f_q.am;
  assign op_tl_o      = op_f_q.tl;
  assign op_ar_o      = op_f_q.ar;
  assign op_dr_o      = op_f_q.dr;
  assign op_rr_o      = op_f_q.rr;
  assign op_sl_o      = op_f_q.sl;
  assign op_wave_o    = op_f_q.wave;
  assign ch_fnum_lo_o = ch_f_q.fnum_lo;
  assign ch_fnum_hi_o = ch_f_q.fnum_hi;
  assign ch_block_o   = ch_f_q.block;
  assign ch_key_o     = ch_f_q.key;
  assign ch_conn_o    = ch_f_q.conn;
  assign ch_fb_o      = ch_f_q.fb;
  assign ch_out_en_o  = ch_f_q.out_en;

  // an upper-channel strobe seen while its pair is active means the drop failed
  logic upper_seen;
  always_comb begin
    int loc, bk;
    loc = int'(ch_idx_o) % CH_PER_BANK;
    bk  = int'(ch_idx_o) / CH_PER_BANK;
    upper_seen = ch_we_o && (ch_grp_o != CG_CONN) && ext_mode_o && (loc >= 3) && (loc <= 5) &&
                 pair_o[bk * PAIRS_PER_BANK + loc - 3];
  end

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({op_we_o, ch_we_o, perc_we_o})); // R14
  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_we_o || ch_we_o || perc_we_o) |-> $past(data_we_i)); // R2
  AST_KEY_WITH_CH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_ev_o |-> (ch_we_o && ch_grp_o == CG_KEY && ch_key_o == key_on_o)); // R10
  AST_UPPER_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upper_seen); // R9
  AST_WAVE_NARROW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_we_o && !ext_mode_o) |-> !op_wave_o[2]); // R7
endmodule

// File: tb/fm_reg_decoder_test.sv
`timescale 1ns/1ps
module fm_reg_decoder_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        addr_we_i = 1'b0;
  logic [0:0]  bank_i = '0;
  logic        data_we_i = 1'b0;
  logic [7:0]  wdata_i = '0;
  logic        op_we_o;
  logic [2:0]  op_grp_o;
  logic [5:0]  op_slot_o;
  logic [3:0]  op_mult_o;
  logic        op_sus_en_o, op_am_o;
  logic [5:0]  op_tl_o;
  logic [4:0]  op_ar_o, op_dr_o, op_rr_o, op_sl_o;
  logic [2:0]  op_wave_o;
  logic        ch_we_o;
  logic [1:0]  ch_grp_o;
  logic [4:0]  ch_idx_o;
  logic [7:0]  ch_fnum_lo_o;
  logic [1:0]  ch_fnum_hi_o;
  logic [2:0]  ch_block_o;
  logic        ch_key_o, ch_conn_o;
  logic [2:0]  ch_fb_o;
  logic [3:0]  ch_out_en_o;
  logic        key_ev_o, key_on_o;
  logic [35:0] key_mask_o;
  logic        perc_we_o;
  logic [7:0]  perc_o;
  logic [5:0]  pair_o;
  logic        ext_mode_o;

  always #4 clk_i = ~clk_i;

  fm_reg_decoder uut (.*);

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 1'b0;

  logic [7:0]  m_addr = 8'h00;
  logic        m_bank = 1'b0;
  logic        m_ext = 1'b0;
  logic [5:0]  m_pair = 6'h00;
  logic [17:0] m_key = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_addr(input logic b, input logic [7:0] a);
    @(negedge clk_i);
    addr_we_i = 1'b1; bank_i = b; wdata_i = a;
    @(negedge clk_i);
    addr_we_i = 1'b0;
    m_addr = a; m_bank = b;
  endtask

  task automatic wr_data(input logic [7:0] d);
    logic [2:0]  g3;
    logic [4:0]  o;
    logic        e_op, hole;
    logic [43:0] e_opv;
    logic [3:0]  hi, c;
    logic        e_ch, paired, e_ev, e_perc, live;
    int          pbit, eslot, eidx, base;
    logic [28:0] e_chv;
    logic [35:0] e_mask;
    logic [4:0]  e_sl;
    live = (m_addr != 8'h00);
    g3 = m_addr[7:5]; o = m_addr[4:0];
    hole = (o == 5'd6) || (o == 5'd7) || (o == 5'd14) || (o == 5'd15) || (o > 5'd21);
    e_op = live && (g3 == 3'd1 || g3 == 3'd2 || g3 == 3'd3 || g3 == 3'd4 || g3 == 3'd7) && !hole;
    eslot = 18 * m_bank + int'(o) - 2 * int'(o >= 5'd8) - 2 * int'(o >= 5'd16);
    e_sl = (d[7:4] == 4'd15) ? 5'd31 : {1'b0, d[7:4]};
    e_opv = {6'(eslot), g3, d[3:0], d[5], d[7], d[5:0], d[7:4], 1'b1, d[3:0], 1'b1,
             d[3:0], 1'b1, e_sl, (m_ext ? d[2:0] : {1'b0, d[1:0]})};
    hi = m_addr[7:4]; c = m_addr[3:0];
    pbit = 3 * m_bank + ((c >= 4'd3) ? int'(c) - 3 : int'(c));
    paired = m_ext && (c < 4'd6) && m_pair[pbit];
    e_ch = live && (hi == 4'hA || hi == 4'hB || hi == 4'hC) && (c <= 4'd8) &&
           !(hi != 4'hC && c >= 4'd3 && paired);
    eidx = 9 * m_bank + int'(c);
    e_chv = {5'(eidx), 2'(int'(hi) - 10), d, d[1:0], d[4:2], d[5], d[0], d[3:1], d[7:4]};
    base = 18 * m_bank + int'(c) + 3 * int'(c >= 4'd3) + 3 * int'(c >= 4'd6);
    e_mask = '0;
    for (int s = 0; s < 36; s++)
      if (s == base || s == base + 3 || (paired && c < 4'd3 && (s == base + 6 || s == base + 9)))
        e_mask[s] = 1'b1;
    e_ev = e_ch && (hi == 4'hB) && (m_key[eidx] != d[5]);
    e_perc = live && !m_bank && (m_addr == 8'hBD);

    @(negedge clk_i);
    data_we_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    data_we_i = 1'b0;

    chk("R3 op strobe", 64'(op_we_o), 64'(e_op));
    if (e_op && op_we_o)
      chk("R3,R4,R5,R6,R7 op fields",
          64'({op_slot_o, op_grp_o, op_mult_o, op_sus_en_o, op_am_o, op_tl_o, op_ar_o,
               op_dr_o, op_rr_o, op_sl_o, op_wave_o}), 64'(e_opv));
    chk("R8,R9 ch strobe", 64'(ch_we_o), 64'(e_ch));
    if (e_ch && ch_we_o)
      chk("R8 ch fields", 64'({ch_idx_o, ch_grp_o, ch_fnum_lo_o, ch_fnum_hi_o, ch_block_o,
                                ch_key_o, ch_conn_o, ch_fb_o, ch_out_en_o}), 64'(e_chv));
    chk("R10 key event", 64'(key_ev_o), 64'(e_ev));
    if (e_ev && key_ev_o) begin
      chk("R10 key polarity", 64'(key_on_o), 64'(d[5]));
      chk("R11 key mask", 64'(key_mask_o), 64'(e_mask));
    end
    chk("R13 perc strobe", 64'(perc_we_o), 64'(e_perc));
    if (e_perc) chk("R13 perc value", 64'(perc_o), 64'(d));
    chk("R14 one target", 64'($countones({op_we_o, ch_we_o, perc_we_o}) <= 1), 64'(1));

    if (e_ch && hi == 4'hB) m_key[eidx] = d[5];
    if (live && !m_bank && m_addr == 8'h04) m_pair = d[5:0];
    if (live && !m_bank && m_addr == 8'h05) m_ext = d[0];
    chk("R12 pairing", 64'(pair_o), 64'(m_pair));
    chk("R12 mode", 64'(ext_mode_o), 64'(m_ext));
  endtask

  task automatic wr(input logic b, input logic [7:0] a, input logic [7:0] d);
    wr_addr(b, a);
    wr_data(d);
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R1 reset state
    chk("R1 strobes", 64'({op_we_o, ch_we_o, key_ev_o, perc_we_o}), 64'(0));
    chk("R1 pair/mode", 64'({pair_o, ext_mode_o}), 64'(0));
    // R2 data with no address ever latched
    wr_data(8'hFF);
    wr(1'b0, 8'h00, 8'h3C);
    // R3 folding and holes
    wr(1'b0, 8'h20, 8'hA5);
    wr(1'b0, 8'h35, 8'h5A);
    wr(1'b0, 8'h26, 8'h11);
    wr(1'b0, 8'h2F, 8'h11);
    wr(1'b0, 8'h36, 8'h11);
    wr(1'b1, 8'h48, 8'h3F);
    wr(1'b1, 8'h92, 8'h12);
    // R5 R6 rates and sustain
    wr(1'b0, 8'h60, 8'h3C);
    wr(1'b0, 8'h80, 8'hF7);
    wr(1'b0, 8'h81, 8'h27);
    // R7 wave narrow then wide
    wr(1'b0, 8'hE0, 8'hFF);
    wr(1'b0, 8'h05, 8'h01);
    wr(1'b0, 8'hE1, 8'hFF);
    // R12 R9 R11 pairing and blocking
    wr(1'b1, 8'h04, 8'h3F);
    wr(1'b0, 8'h04, 8'h3F);
    wr(1'b0, 8'hB3, 8'h20);
    wr(1'b0, 8'hA4, 8'h55);
    wr(1'b0, 8'hC3, 8'hF1);
    wr(1'b0, 8'hB0, 8'h2D);
    wr(1'b0, 8'hB0, 8'h2D);
    wr(1'b0, 8'hB0, 8'h0D);
    wr(1'b1, 8'hB1, 8'h20);
    wr(1'b1, 8'hB6, 8'h20);
    // R8 R13 ignored channel addresses and percussion
    wr(1'b0, 8'hA9, 8'h77);
    wr(1'b0, 8'hD0, 8'h77);
    wr(1'b0, 8'hBD, 8'hC3);
    wr(1'b1, 8'hBD, 8'hC3);
    wr(1'b0, 8'h05, 8'h00);
    wr(1'b0, 8'hB4, 8'h20);
    wr(1'b0, 8'hB4, 8'h00);
    // random mix
    for (int i = 0; i < 600; i++) begin
      logic       b;
      logic [7:0] a;
      int         pick;
      b = 1'($urandom());
      pick = int'($urandom_range(0, 99));
      if (pick < 6)       a = 8'h04 + 8'($urandom_range(0, 1));
      else if (pick < 9)  a = 8'hBD;
      else if (pick < 45) a = 8'hA0 + 8'($urandom_range(0, 47));
      else if (pick < 50) a = 8'($urandom_range(0, 31));
      else                a = 8'($urandom_range(32, 255));
      if (pick < 45 && $urandom_range(0, 1) == 1) a = {a[7:4], 4'($urandom_range(0, 8))};
      wr(b, a, 8'($urandom()));
      if ($urandom_range(0, 3) == 0) wr_data(8'($urandom()));
    end
    done = 1'b1;
    summary();
    $finish;
  end
endmodule